// File: doc/BRIEF.md
# CAN Error Confinement and Bus-Off Recovery

This block holds the fault-confinement state of a CAN node. It keeps a transmit error counter and a receive error counter. The bit-stream processor moves them with single-step and eight-step increment requests and with decrement requests. The block compares both counters against a programmable warning threshold and reports an error-status flag and a bus-status (bus-off) flag. Each change of either flag produces a one-cycle error event for the interrupt logic.

A transmit counter that would pass its maximum drives the node off the bus and forces the host-visible reset request. The node then stays in reset mode until the host clears that request. After the clear, the block watches the sampled bus input for bus-idle sequences, each one made of eleven consecutive recessive bits, and brings the node back on line once enough have been seen. Recovery from bus-off needs 128 such sequences and also zeroes both counters. Leaving a reset that the host or the block reset caused needs only one sequence. A node woken from sleep by bus activity also waits for one sequence before it takes part again.

Top module: `can_err_confine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters reset mode: `reset_req_o`=1, `bus_off_o`=0, `node_online_o`=0, both counters 0, warning limit 96, and `err_status_o`=0.
- R2: While on line, each counter takes the value old + 8·inc8 + inc − dec in the cycle after the requests. The receive counter saturates at 255 and neither counter goes below 0.
- R3: `err_status_o` is 1 exactly when the transmit or the receive counter is greater than or equal to the warning limit.
- R4: A transmit update that would go above 255 holds the counter at 255 and sets `bus_off_o`=1 and `reset_req_o`=1 in the next cycle.
- R5: `err_event_o` is high for one cycle, one cycle after `err_status_o` or `bus_off_o` changes value.
- R6: While `node_online_o` is 0, counter increment and decrement requests have no effect.
- R7: Host writes (`host_sel_i` 0 = transmit counter, 1 = receive counter, 2 = warning limit) take effect only while `reset_req_o` is 1. In any other mode they are ignored.
- R8: After the host clears a reset request that was not caused by bus-off, the node goes on line after one sequence of 11 consecutive recessive bits. Bits are sampled on `bit_tick_i`, with `rx_bit_i`=1 meaning recessive. Any dominant sample restarts the count.
- R9: After a bus-off reset request is cleared, the node stays off line through 127 bus-idle sequences. At the 128th sequence it clears `bus_off_o`, zeroes both counters and goes on line.
- R10: A clear of the reset request has no effect while `rst_n` is low. A host set of the reset request takes the node off line into reset mode.
- R11: A `wake_bus_i` pulse while on line takes the node off line until one more bus-idle sequence has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick_i | input | 1 | One-cycle strobe at each bus sample point |
| rx_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| tec_inc_i | input | 1 | Transmit counter +1 request |
| tec_inc8_i | input | 1 | Transmit counter +8 request |
| tec_dec_i | input | 1 | Transmit counter −1 request |
| rec_inc_i | input | 1 | Receive counter +1 request |
| rec_inc8_i | input | 1 | Receive counter +8 request |
| rec_dec_i | input | 1 | Receive counter −1 request |
| host_rreq_set_i | input | 1 | Host sets the reset request |
| host_rreq_clr_i | input | 1 | Host clears the reset request |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_i | input | 2 | Write target: 0 transmit counter, 1 receive counter, 2 limit |
| host_wdata_i | input | 8 | Host write data |
| wake_bus_i | input | 1 | Wake-up caused by bus activity |
| reset_req_o | output | 1 | Reset request (reset mode) |
| bus_off_o | output | 1 | Bus status, 1 = bus-off |
| err_status_o | output | 1 | A counter is at or above the warning limit |
| node_online_o | output | 1 | Node takes part in bus traffic |
| err_event_o | output | 1 | One-cycle error event |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| warn_limit_o | output | 8 | Warning limit |

## Verification
A wrong internal state shows up at the counter ports one cycle after the request that exposed it. The status flags react in the same cycle, and the error event follows one cycle later. A fault in the bus-idle run counter or in the recovery counter shows only at `node_online_o`, either when the final recessive bit of a sequence arrives or when it fails to. For this reason the bench counts bits exactly up to the edge of each sequence, checks one bit short of the edge, and checks the 127th and 128th bus-off sequences separately.

// File: rtl/canfc_pkg.sv
// Shared types and encodings for the CAN error-confinement block.
// Assumes: a single clock domain; every consumer imports this package.
package canfc_pkg;

    // Node participation mode.
    typedef enum logic [1:0] {
        MODE_RESET  = 2'd0,
        MODE_WAIT   = 2'd1,
        MODE_ONLINE = 2'd2
    } node_mode_e;

    // Host write targets.
    localparam logic [1:0] SEL_TEC = 2'd0;
    localparam logic [1:0] SEL_REC = 2'd1;
    localparam logic [1:0] SEL_LIM = 2'd2;

endpackage

// File: rtl/canfc_err_counters.sv
// Transmit and receive error counters.
// Requests from the bit-stream processor count only while online_i is high.
// Host writes come in already qualified by reset mode. clr_i zeroes both
// counters and has the highest priority. The transmit counter flags an
// overflow instead of wrapping. The receive counter saturates.
module canfc_err_counters #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             online_i,
    input  logic             clr_i,
    input  logic             wr_tec_i,
    input  logic             wr_rec_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             tec_inc_i,
    input  logic             tec_inc8_i,
    input  logic             tec_dec_i,
    input  logic             rec_inc_i,
    input  logic             rec_inc8_i,
    input  logic             rec_dec_i,
    output logic [CNT_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o,
    output logic             tec_ovf_o
);
    localparam int SW = CNT_W + 2;
    localparam logic [SW-1:0] CNT_MAX = SW'((1 << CNT_W) - 1);

    logic [CNT_W-1:0] tec_q, rec_q;
    logic [SW-1:0]    tec_sum, rec_sum, tec_nx, rec_nx;

    // Requested next values, floored at zero.
    always_comb begin
        tec_sum = SW'(tec_q) + (tec_inc8_i ? SW'(8) : SW'(0)) + SW'(tec_inc_i);
        rec_sum = SW'(rec_q) + (rec_inc8_i ? SW'(8) : SW'(0)) + SW'(rec_inc_i);
        tec_nx  = tec_sum - SW'(tec_dec_i && (tec_sum != '0));
        rec_nx  = rec_sum - SW'(rec_dec_i && (rec_sum != '0));
    end

    assign tec_ovf_o = online_i && (tec_nx > CNT_MAX);

    // Transmit counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)      tec_q <= '0;
        else if (wr_tec_i)        tec_q <= wr_data_i;
        else if (online_i) begin
            if (tec_nx > CNT_MAX) tec_q <= CNT_MAX[CNT_W-1:0];
            else                  tec_q <= tec_nx[CNT_W-1:0];
        end
    end

    // Receive counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)      rec_q <= '0;
        else if (wr_rec_i)        rec_q <= wr_data_i;
        else if (online_i) begin
            if (rec_nx > CNT_MAX) rec_q <= CNT_MAX[CNT_W-1:0];
            else                  rec_q <= rec_nx[CNT_W-1:0];
        end
    end

    assign tec_o = tec_q;
    assign rec_o = rec_q;

    AST_TEC_FROZEN_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!online_i && !wr_tec_i && !clr_i) |=> $stable(tec_q)); // R6
    AST_REC_FROZEN_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!online_i && !wr_rec_i && !clr_i) |=> $stable(rec_q)); // R6
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (tec_q == '0 && rec_q == '0)); // R9

endmodule

// File: rtl/canfc_busfree.sv
// Bus-idle detector. Counts recessive samples taken on bit_tick_i and gives
// a one-cycle seq_done_o after IDLE_BITS of them in a row. A dominant sample
// or restart_i starts the run again. After a completed run the count begins
// afresh.
module canfc_busfree #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic bit_tick_i,
    input  logic rx_i,
    output logic seq_done_o
);
    localparam int RW = $clog2(IDLE_BITS + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(IDLE_BITS - 1);

    logic [RW-1:0] run_q;
    logic          done_q;

    // Run-length counter and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            run_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (bit_tick_i) begin
                if (!rx_i) begin
                    run_q <= '0;
                end else if (run_q == RUN_LAST) begin
                    run_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    run_q <= run_q + RW'(1);
                end
            end
        end
    end

    assign seq_done_o = done_q;

    AST_DONE_AFTER_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |-> ($past(rx_i) && $past(bit_tick_i))); // R8
    AST_RUN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_LAST); // R8

endmodule

// File: rtl/canfc_mode_ctl.sv
// Mode controller: reset mode, waiting for bus idle, and online.
// Tracks the bus-off flag and counts bus-idle sequences during recovery.
// Assumes seq_done_i is a one-cycle strobe from the bus-idle detector.
// Drives restart_o whenever a wait begins, so that partial runs left
// over from before do not count.
module canfc_mode_ctl
    import canfc_pkg::*;
#(
    parameter int BUSOFF_SEQS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_set_i,
    input  logic host_clr_i,
    input  logic tec_ovf_i,
    input  logic seq_done_i,
    input  logic wake_i,
    output logic reset_req_o,
    output logic bus_off_o,
    output logic online_o,
    output logic restart_o,
    output logic clr_cnt_o
);
    localparam int SEQ_W = $clog2(BUSOFF_SEQS + 1);
    localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(BUSOFF_SEQS - 1);

    node_mode_e       mode_q;
    logic             busoff_q;
    logic [SEQ_W-1:0] seq_cnt_q;
    logic             last_seq;

    // The bus-off recovery needs the full count; any other wait needs one sequence.
    assign last_seq  = busoff_q ? (seq_cnt_q == SEQ_LAST) : 1'b1;
    assign restart_o = ((mode_q == MODE_RESET) && host_clr_i) ||
                       ((mode_q == MODE_ONLINE) && wake_i && !tec_ovf_i && !host_set_i);
    assign clr_cnt_o = (mode_q == MODE_WAIT) && !host_set_i && seq_done_i &&
                       last_seq && busoff_q;

    // Mode, bus-off flag and recovery sequence counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_RESET;
            busoff_q  <= 1'b0;
            seq_cnt_q <= '0;
        end else begin
            unique case (mode_q)
                MODE_RESET: begin
                    if (host_clr_i) begin
                        mode_q    <= MODE_WAIT;
                        seq_cnt_q <= '0;
                    end
                end
                MODE_WAIT: begin
                    if (host_set_i) begin
                        mode_q <= MODE_RESET;
                    end else if (seq_done_i) begin
                        if (last_seq) begin
                            mode_q    <= MODE_ONLINE;
                            busoff_q  <= 1'b0;
                            seq_cnt_q <= '0;
                        end else begin
                            seq_cnt_q <= seq_cnt_q + SEQ_W'(1);
                        end
                    end
                end
                MODE_ONLINE: begin
                    if (tec_ovf_i) begin
                        mode_q   <= MODE_RESET;
                        busoff_q <= 1'b1;
                    end else if (host_set_i) begin
                        mode_q <= MODE_RESET;
                    end else if (wake_i) begin
                        mode_q    <= MODE_WAIT;
                        seq_cnt_q <= '0;
                    end
                end
                default: mode_q <= MODE_RESET;
            endcase
        end
    end

    assign reset_req_o = (mode_q == MODE_RESET);
    assign online_o    = (mode_q == MODE_ONLINE);
    assign bus_off_o   = busoff_q;

    AST_RREQ_ON_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off_o) |-> reset_req_o); // R4
    AST_ONLINE_NOT_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        online_o |-> !bus_off_o); // R9
    AST_SEQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        seq_cnt_q <= SEQ_LAST); // R9
    AST_SET_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (host_set_i && !reset_req_o) |=> reset_req_o); // R10

endmodule

// File: rtl/can_err_confine.sv
// Top level of the CAN error-confinement block. Joins the counters, the
// bus-idle detector and the mode controller, and holds the warning limit.
// Works out the error status and produces the error event, which comes one
// cycle after a status or bus-off change. Assumes rst_n is synchronous.
module can_err_confine
    import canfc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DEF_LIMIT   = 96,
    parameter int IDLE_BITS   = 11,
    parameter int BUSOFF_SEQS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick_i,
    input  logic             rx_bit_i,
    input  logic             tec_inc_i,
    input  logic             tec_inc8_i,
    input  logic             tec_dec_i,
    input  logic             rec_inc_i,
    input  logic             rec_inc8_i,
    input  logic             rec_dec_i,
    input  logic             host_rreq_set_i,
    input  logic             host_rreq_clr_i,
    input  logic             host_wr_i,
    input  logic [1:0]       host_sel_i,
    input  logic [CNT_W-1:0] host_wdata_i,
    input  logic             wake_bus_i,
    output logic             reset_req_o,
    output logic             bus_off_o,
    output logic             err_status_o,
    output logic             node_online_o,
    output logic             err_event_o,
    output logic [CNT_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o,
    output logic [CNT_W-1:0] warn_limit_o
);
    logic             online, rreq, busoff, restart, clr_cnt, tec_ovf, seq_done;
    logic             wr_tec, wr_rec, wr_lim;
    logic [CNT_W-1:0] tec, rec, limit_q;
    logic             es, es_q, bo_q, evt_q;

    // Host writes are honoured in reset mode only.
    assign wr_tec = host_wr_i && rreq && (host_sel_i == SEL_TEC);
    assign wr_rec = host_wr_i && rreq && (host_sel_i == SEL_REC);
    assign wr_lim = host_wr_i && rreq && (host_sel_i == SEL_LIM);

    canfc_err_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .online_i   (online),
        .clr_i      (clr_cnt),
        .wr_tec_i   (wr_tec),
        .wr_rec_i   (wr_rec),
        .wr_data_i  (host_wdata_i),
        .tec_inc_i  (tec_inc_i),
        .tec_inc8_i (tec_inc8_i),
        .tec_dec_i  (tec_dec_i),
        .rec_inc_i  (rec_inc_i),
        .rec_inc8_i (rec_inc8_i),
        .rec_dec_i  (rec_dec_i),
        .tec_o      (tec),
        .rec_o      (rec),
        .tec_ovf_o  (tec_ovf)
    );

    canfc_busfree #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .bit_tick_i (bit_tick_i),
        .rx_i       (rx_bit_i),
        .seq_done_o (seq_done)
    );

    canfc_mode_ctl #(.BUSOFF_SEQS(BUSOFF_SEQS)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_set_i  (host_rreq_set_i),
        .host_clr_i  (host_rreq_clr_i),
        .tec_ovf_i   (tec_ovf),
        .seq_done_i  (seq_done),
        .wake_i      (wake_bus_i),
        .reset_req_o (rreq),
        .bus_off_o   (busoff),
        .online_o    (online),
        .restart_o   (restart),
        .clr_cnt_o   (clr_cnt)
    );

    // Warning limit register.
    always_ff @(posedge clk) begin
        if (!rst_n)      limit_q <= CNT_W'(DEF_LIMIT);
        else if (wr_lim) limit_q <= host_wdata_i;
    end

    assign es = (tec >= limit_q) || (rec >= limit_q);

    // Change detector for the error event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            es_q  <= 1'b0;
            bo_q  <= 1'b0;
            evt_q <= 1'b0;
        end else begin
            es_q  <= es;
            bo_q  <= busoff;
            evt_q <= (es != es_q) || (busoff != bo_q);
        end
    end

    assign reset_req_o   = rreq;
    assign bus_off_o     = busoff;
    assign err_status_o  = es;
    assign node_online_o = online;
    assign err_event_o   = evt_q;
    assign tec_o         = tec;
    assign rec_o         = rec;
    assign warn_limit_o  = limit_q;

    AST_EVT_AFTER_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off_o) |=> err_event_o); // R5
    AST_ZERO_AFTER_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_off_o) |-> (tec_o == '0 && rec_o == '0)); // R9
    AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_req_o |=> $stable(warn_limit_o)); // R7
    AST_TEC_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off_o) |-> (tec_o == {CNT_W{1'b1}})); // R4

endmodule

// File: tb/can_err_confine_tb.sv
// Self-checking bench: a table of counter-request vectors, then directed
// tests for reset, the mode rules, wake-up and bus-off recovery.
module can_err_confine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 0, rx_bit = 1;
    logic       t_inc = 0, t_inc8 = 0, t_dec = 0, r_inc = 0, r_inc8 = 0, r_dec = 0;
    logic       h_set = 0, h_clr = 0, h_wr = 0, wake = 0;
    logic [1:0] h_sel = 0;
    logic [7:0] h_data = 0;
    logic       reset_req, bus_off, err_status, online, err_event;
    logic [7:0] tec, rec, lim;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    can_err_confine u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick_i(bit_tick), .rx_bit_i(rx_bit),
        .tec_inc_i(t_inc), .tec_inc8_i(t_inc8), .tec_dec_i(t_dec),
        .rec_inc_i(r_inc), .rec_inc8_i(r_inc8), .rec_dec_i(r_dec),
        .host_rreq_set_i(h_set), .host_rreq_clr_i(h_clr), .host_wr_i(h_wr),
        .host_sel_i(h_sel), .host_wdata_i(h_data), .wake_bus_i(wake),
        .reset_req_o(reset_req), .bus_off_o(bus_off), .err_status_o(err_status),
        .node_online_o(online), .err_event_o(err_event),
        .tec_o(tec), .rec_o(rec), .warn_limit_o(lim)
    );

    // Rows: {tec_inc, tec_inc8, tec_dec, rec_inc, rec_inc8, rec_dec, exp_tec, exp_rec, exp_es}
    localparam int NV = 6;
    localparam logic [22:0] VEC [NV] = '{
        {6'b000001, 8'd0,  8'd0,  1'b0},
        {6'b010000, 8'd8,  8'd0,  1'b0},
        {6'b100010, 8'd9,  8'd8,  1'b0},
        {6'b001001, 8'd8,  8'd7,  1'b0},
        {6'b110110, 8'd17, 8'd16, 1'b0},
        {6'b101101, 8'd17, 8'd16, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic lvl);
        rx_bit = lvl; bit_tick = 1'b1;
        step();
        bit_tick = 1'b0; rx_bit = 1'b1;
        step();
    endtask

    task automatic send_seqs(input int n);
        for (int s = 0; s < n; s++)
            for (int b = 0; b < 11; b++) send_bit(1'b1);
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
        h_wr = 1'b1; h_sel = sel; h_data = d;
        step();
        h_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        h_clr = 1'b1;
        step();
        h_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step();
        // R10: clearing is blocked while reset is held
        h_clr = 1'b1;
        step();
        h_clr = 1'b0;
        chk("R10 rreq held in reset", reset_req, 1);
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk("R1 reset_req", reset_req, 1);
        chk("R1 bus_off", bus_off, 0);
        chk("R1 online", online, 0);
        chk("R1 tec", tec, 0);
        chk("R1 rec", rec, 0);
        chk("R1 limit", lim, 96);
        chk("R1 err_status", err_status, 0);

        // R8: one bus-idle sequence after a non-bus-off reset, dominant restarts
        pulse_clr();
        chk("R8 rreq cleared", reset_req, 0);
        for (int b = 0; b < 10; b++) send_bit(1'b1);
        send_bit(1'b0);
        for (int b = 0; b < 10; b++) send_bit(1'b1);
        chk("R8 dominant restarts run", online, 0);
        send_bit(1'b1);
        chk("R8 online after 11 recessive", online, 1);

        // R2/R3: vector table
        for (int i = 0; i < NV; i++) begin
            {t_inc, t_inc8, t_dec, r_inc, r_inc8, r_dec} = VEC[i][22:17];
            step();
            {t_inc, t_inc8, t_dec, r_inc, r_inc8, r_dec} = 6'b0;
            chk($sformatf("R2 tec row %0d", i), tec, int'(VEC[i][16:9]));
            chk($sformatf("R2 rec row %0d", i), rec, int'(VEC[i][8:1]));
            chk($sformatf("R3 err_status row %0d", i), err_status, int'(VEC[i][0]));
        end

        // R7: writes ignored while online
        host_write(2'd2, 8'd5);
        host_write(2'd0, 8'd200);
        chk("R7 limit ignored online", lim, 96);
        chk("R7 tec ignored online", tec, 17);

        // R11: wake from bus activity; R6: requests ignored offline
        wake = 1'b1;
        step();
        wake = 1'b0;
        chk("R11 offline after wake", online, 0);
        t_inc8 = 1'b1; r_inc = 1'b1;
        step();
        t_inc8 = 1'b0; r_inc = 1'b0;
        chk("R6 tec ignored offline", tec, 17);
        chk("R6 rec ignored offline", rec, 16);
        for (int b = 0; b < 10; b++) send_bit(1'b1);
        chk("R11 still offline", online, 0);
        send_bit(1'b1);
        chk("R11 online after idle", online, 1);

        // R10: host set enters reset mode; R7 writes allowed there; R3/R5
        h_set = 1'b1;
        step();
        h_set = 1'b0;
        chk("R10 host set", reset_req, 1);
        chk("R10 offline", online, 0);
        host_write(2'd2, 8'd20);
        chk("R7 limit written", lim, 20);
        chk("R3 below limit", err_status, 0);
        host_write(2'd1, 8'd20);
        chk("R7 rec written", rec, 20);
        chk("R3 rec at limit", err_status, 1);
        chk("R5 no event yet", err_event, 0);
        step();
        chk("R5 event after status change", err_event, 1);
        step();
        chk("R5 event one cycle", err_event, 0);

        // R1 again: reset restores the limit and counters
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R1 limit restored", lim, 96);
        chk("R1 rec cleared", rec, 0);

        // R4/R9: bus-off and its recovery
        host_write(2'd0, 8'd250);
        step(); step();
        pulse_clr();
        send_seqs(1);
        chk("R8 online for bus-off test", online, 1);
        t_inc8 = 1'b1;
        step();
        t_inc8 = 1'b0;
        chk("R4 bus_off", bus_off, 1);
        chk("R4 reset_req", reset_req, 1);
        chk("R4 tec saturated", tec, 255);
        step();
        chk("R5 event on bus-off", err_event, 1);
        t_dec = 1'b1;
        step();
        t_dec = 1'b0;
        chk("R6 tec frozen in bus-off", tec, 255);
        pulse_clr();
        chk("R9 rreq cleared", reset_req, 0);
        send_seqs(127);
        chk("R9 still bus-off after 127", bus_off, 1);
        chk("R9 offline after 127", online, 0);
        send_seqs(1);
        chk("R9 bus-on after 128", bus_off, 0);
        chk("R9 online after 128", online, 1);
        chk("R9 tec zeroed", tec, 0);
        chk("R9 err_status clear", err_status, 0);
        step();
        chk("R5 event on recovery", err_event, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule